// File: doc/BRIEF.md
# SPI Flash Command Controller

This block lets software talk to serial flash memories through a small register window. It drives one of four chip-select lines and runs the serial bus with the clock idling high. Data goes out on each falling clock edge and comes in on each rising edge (SPI mode 3). The serial clock is the system clock divided by the even parameter `CLK_DIV`.

Software loads up to four command bytes into the transmit register and then writes the second control register. That write picks the chip select, the number of bytes to send and receive, and one of three transfer types: a generic send/receive, a status read, or a write-enable. The status read and write-enable send their fixed opcodes without software preparing the transmit register. When a transfer ends, the block raises a sticky finish flag. Software polls the flag and clears it by writing the status register with that bit at zero.

The sequencer states are IDLE, LEAD, LOW, HIGH, TRAIL, GAP and DONE:
- IDLE→LEAD: an accepted start.
- LEAD→LOW: after half an SPI period, when bits are pending. LEAD→TRAIL: when the bit count is zero.
- LOW→HIGH: after half a period. This transition samples the input line.
- HIGH→LOW: another bit remains. HIGH→TRAIL: the last bit is done.
- TRAIL→GAP: after half a period. The chip select is released here.
- GAP→DONE: after a full SPI period with the chip select high.
- DONE→IDLE: one cycle, which sets the flag.

Top module: `spi_flash_cmd_ctrl`

## Requirements
- R1: After reset every register reads 0, all four chip-select outputs are high, and the serial clock is high.
- R2: The serial clock is high whenever no chip select is low. Serial data out changes only while the clock is low, and never during a high phase. Serial data in is captured at each rising clock edge.
- R3: Registers sit at byte offsets 0x00 (control A), 0x04 (control B), 0x08 (status), 0x0C (transmit) and 0x10 (receive). Control A keeps only bits 29 and 28; all its other bits read 0.
- R4: Writing control B with bit 7 set starts a generic transfer. Bits [2:0] give the number of bytes to send and bits [6:4] the number to receive. Each count is limited to 4, and a larger value acts as 4.
- R5: The transmit register goes out byte 0 (bits [7:0]) first, then bytes 1, 2 and 3. Each byte is sent most significant bit first. Serial data out is 0 during receive bytes.
- R6: The receive register is updated only by a generic transfer whose receive count is non-zero. The first received byte lands in the most significant used byte, and each later byte sits one byte lower. The final byte ends in bits [7:0] and unused upper bytes are 0. A transfer with receive count 0 leaves the register unchanged.
- R7: Bit 10 of control B sends opcode 0x05 and receives one byte, which appears in status bits [7:0]. Status bits [7:0] are not writable.
- R8: Bit 11 of control B sends opcode 0x06 as a one-byte transfer. When several start bits are set together, bit 11 wins over bit 10, and bit 10 wins over bit 7.
- R9: Control B bits [13:12] pick the chip select: value n drives chip-select output n low. At most one chip select is ever low.
- R10: Status bit 8 is the finish flag and is set when a transfer ends. A status write with bit 8 at 0 clears the flag. A status write with bit 8 at 1 leaves it set. If a transfer ends in the same cycle as a clearing write, the flag is set.
- R11: The chip select stays low for the whole transfer, with exactly one falling edge per transfer. It has been high for at least `CLK_DIV` system cycles when the finish flag rises.
- R12: A control B write that arrives while a transfer is in progress changes nothing: the register keeps its value and no new transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register byte offset |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_cs_n | output | 4 | Active-low chip selects |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The hardest case to reach is a control B write that lands while the sequencer is mid-transfer. Such a write must not disturb the register or the bank in use. The bench starts a long five-byte transfer and issues a conflicting control B write on the very next bus cycle. It then checks the readback, the count of chip-select falling edges, and which chip select the flash responder saw. A behavioural flash responder returns ID, status and pattern bytes. This lets the bench check receive packing when replies start partway through a multi-byte command, and check the write-enable latch through a later status read.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    localparam int CS_BITS = 2;
    localparam int NUM_CS  = 1 << CS_BITS;
    localparam int DW      = 32;
    localparam int CNT_W   = 7;   // bit totals up to 64

    localparam logic [4:0] OFS_CTRLA = 5'h00;
    localparam logic [4:0] OFS_CTRLB = 5'h04;
    localparam logic [4:0] OFS_STAT  = 5'h08;
    localparam logic [4:0] OFS_TXD   = 5'h0C;
    localparam logic [4:0] OFS_RXD   = 5'h10;

    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WREN = 8'h06;

    localparam int B_SEND = 7;
    localparam int B_RDSR = 10;
    localparam int B_WREN = 11;
    localparam int B_FIN  = 8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LEAD, ST_LOW, ST_HIGH, ST_TRAIL, ST_GAP, ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] { K_SEND, K_RDSR, K_WREN } xfer_kind_t;

    typedef struct packed {
        logic [CNT_W-1:0]   tx_bits;
        logic [CNT_W-1:0]   rx_bits;
        logic [CS_BITS-1:0] bank;
        logic [DW-1:0]      load;
    } xfer_req_t;
endpackage

// File: rtl/sfc_regs.sv
module sfc_regs
    import sfc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [4:0]    addr,
    input  logic [DW-1:0] wdata,
    input  logic          busy,
    input  logic          done,
    input  logic [DW-1:0] rx_word,
    output logic [DW-1:0] rdata,
    output logic          start,
    output xfer_req_t     req,
    output logic          fin_flag,
    output logic [DW-1:0] ctrlb_val
);
    logic [1:0]    ctrla_q;
    logic [DW-1:0] ctrlb_q, tx_q, rx_q;
    logic [7:0]    stat_q;
    logic          fin_q, rx_used_q, trig;
    xfer_kind_t    kind_q, kind_d;
    logic [2:0]    txn, rxn;
    logic [DW-1:0] ser, mask;

    always_comb begin
        txn    = (wdata[2:0] > 3'd4) ? 3'd4 : wdata[2:0];
        rxn    = (wdata[6:4] > 3'd4) ? 3'd4 : wdata[6:4];
        ser    = {tx_q[7:0], tx_q[15:8], tx_q[23:16], tx_q[31:24]};
        mask   = ~({DW{1'b1}} >> {txn, 3'b000});
        req    = '0;
        kind_d = K_SEND;
        trig   = 1'b0;
        req.bank = wdata[13:12];
        if (wdata[B_WREN]) begin
            trig = 1'b1;  kind_d = K_WREN;
            req.tx_bits = CNT_W'(8);
            req.load = {OP_WREN, 24'h0};
        end else if (wdata[B_RDSR]) begin
            trig = 1'b1;  kind_d = K_RDSR;
            req.tx_bits = CNT_W'(8);
            req.rx_bits = CNT_W'(8);
            req.load = {OP_RDSR, 24'h0};
        end else if (wdata[B_SEND]) begin
            trig = 1'b1;  kind_d = K_SEND;
            req.tx_bits = {1'b0, txn, 3'b000};
            req.rx_bits = {1'b0, rxn, 3'b000};
            req.load = ser & mask;
        end
        start = trig && wr_en && (addr == OFS_CTRLB) && !busy;
    end

    always_comb begin
        case (addr)
            OFS_CTRLA: rdata = {2'b00, ctrla_q, 28'h0};
            OFS_CTRLB: rdata = ctrlb_q;
            OFS_STAT:  rdata = {23'h0, fin_q, stat_q};
            OFS_TXD:   rdata = tx_q;
            OFS_RXD:   rdata = rx_q;
            default:   rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrla_q   <= '0;
            ctrlb_q   <= '0;
            tx_q      <= '0;
            rx_q      <= '0;
            stat_q    <= '0;
            fin_q     <= 1'b0;
            rx_used_q <= 1'b0;
            kind_q    <= K_SEND;
        end else begin
            if (wr_en && addr == OFS_CTRLA) ctrla_q <= wdata[29:28];
            if (wr_en && addr == OFS_CTRLB && !busy) ctrlb_q <= wdata;
            if (wr_en && addr == OFS_TXD) tx_q <= wdata;
            if (start) begin
                kind_q    <= kind_d;
                rx_used_q <= (req.rx_bits != '0);
            end
            if (wr_en && addr == OFS_STAT && !wdata[B_FIN]) fin_q <= 1'b0;
            if (done) begin
                fin_q <= 1'b1;
                if (kind_q == K_RDSR) stat_q <= rx_word[7:0];
                if (kind_q == K_SEND && rx_used_q) rx_q <= rx_word;
            end
        end
    end

    assign fin_flag  = fin_q;
    assign ctrlb_val = ctrlb_q;
endmodule

// File: rtl/sfc_seq.sv
module sfc_seq
    import sfc_pkg::*;
#(
    parameter int CLK_DIV = 4
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CNT_W-1:0]   tx_bits,
    input  logic [CNT_W-1:0]   rx_bits,
    input  logic [CS_BITS-1:0] bank,
    output logic               sck,
    output logic [NUM_CS-1:0]  cs_n,
    output logic               busy,
    output logic               done,
    output logic               shift_en,
    output logic               sample_en
);
    localparam int HALF = CLK_DIV / 2;
    localparam int TW   = $clog2(CLK_DIV + 1);

    seq_state_t         state_q, nxt;
    logic [TW-1:0]      tmr_q;
    logic [CNT_W-1:0]   bit_q, total_q, txb_q;
    logic [CS_BITS-1:0] bank_q;
    logic               tmr_zero, cs_act;

    assign tmr_zero = (tmr_q == '0);

    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) nxt = ST_LEAD;
            ST_LEAD:  if (tmr_zero) nxt = (total_q == '0) ? ST_TRAIL : ST_LOW;
            ST_LOW:   if (tmr_zero) nxt = ST_HIGH;
            ST_HIGH:  if (tmr_zero) nxt = (bit_q == total_q - 1'b1) ? ST_TRAIL : ST_LOW;
            ST_TRAIL: if (tmr_zero) nxt = ST_GAP;
            ST_GAP:   if (tmr_zero) nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q   <= '0;
            bit_q   <= '0;
            total_q <= '0;
            txb_q   <= '0;
            bank_q  <= '0;
        end else begin
            if (nxt != state_q)
                tmr_q <= (nxt == ST_GAP) ? TW'(CLK_DIV - 1) : TW'(HALF - 1);
            else if (!tmr_zero)
                tmr_q <= tmr_q - 1'b1;
            if (start && state_q == ST_IDLE) begin
                bit_q   <= '0;
                total_q <= tx_bits + rx_bits;
                txb_q   <= tx_bits;
                bank_q  <= bank;
            end else if (state_q == ST_HIGH && tmr_zero) begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    always_comb begin
        cs_act    = (state_q == ST_LEAD) || (state_q == ST_LOW) ||
                    (state_q == ST_HIGH) || (state_q == ST_TRAIL);
        sck       = (state_q != ST_LOW);
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_DONE);
        shift_en  = (nxt == ST_LOW) && (state_q != ST_LOW);
        sample_en = (state_q == ST_LOW) && (nxt == ST_HIGH) && (bit_q >= txb_q);
        for (int i = 0; i < NUM_CS; i++)
            cs_n[i] = !(cs_act && bank_q == CS_BITS'(i));
    end
endmodule

// File: rtl/sfc_shift.sv
module sfc_shift
    import sfc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_word,
    input  logic          shift_en,
    input  logic          sample_en,
    input  logic          miso,
    output logic          mosi,
    output logic [DW-1:0] rx_word
);
    logic [DW-1:0] sreg_q, acc_q;
    logic          mosi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            acc_q  <= '0;
            mosi_q <= 1'b0;
        end else if (load) begin
            sreg_q <= load_word;
            acc_q  <= '0;
        end else begin
            if (shift_en) begin
                mosi_q <= sreg_q[DW-1];
                sreg_q <= {sreg_q[DW-2:0], 1'b0};
            end
            if (sample_en) acc_q <= {acc_q[DW-2:0], miso};
        end
    end

    assign mosi    = mosi_q;
    assign rx_word = acc_q;
endmodule

// File: rtl/spi_flash_cmd_ctrl.sv
module spi_flash_cmd_ctrl
    import sfc_pkg::*;
#(
    parameter int CLK_DIV = 4
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [4:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        spi_sck,
    output logic [3:0]  spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    logic          busy, done, start, fin_flag, shift_en, sample_en;
    logic [DW-1:0] rx_word, ctrlb_val;
    xfer_req_t     req;

    sfc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .busy(busy), .done(done), .rx_word(rx_word), .rdata(rdata),
        .start(start), .req(req), .fin_flag(fin_flag), .ctrlb_val(ctrlb_val)
    );

    sfc_seq #(.CLK_DIV(CLK_DIV)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_bits(req.tx_bits),
        .rx_bits(req.rx_bits), .bank(req.bank), .sck(spi_sck), .cs_n(spi_cs_n),
        .busy(busy), .done(done), .shift_en(shift_en), .sample_en(sample_en)
    );

    sfc_shift u_shift (
        .clk(clk), .rst_n(rst_n), .load(start), .load_word(req.load),
        .shift_en(shift_en), .sample_en(sample_en), .miso(spi_miso),
        .mosi(spi_mosi), .rx_word(rx_word)
    );
endmodule

// File: rtl/sfc_chk.sv
module sfc_chk
    import sfc_pkg::*;
#(
    parameter int CLK_DIV = 4
)(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [4:0]  addr,
    input logic [31:0] wdata,
    input logic        spi_sck,
    input logic [3:0]  spi_cs_n,
    input logic        spi_mosi,
    input logic        fin_flag,
    input logic        busy,
    input logic        done,
    input logic [31:0] ctrlb_val
);
    logic [15:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              hi_cnt <= '0;
        else if (!(&spi_cs_n))   hi_cnt <= '0;
        else if (hi_cnt != '1)   hi_cnt <= hi_cnt + 1'b1;
    end

    // R9
    one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~spi_cs_n));
    // R2
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&spi_cs_n) |-> spi_sck);
    // R2
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&spi_cs_n) && spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));
    // R12
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && addr == OFS_CTRLB) |=> $stable(ctrlb_val));
    // R10
    fin_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_STAT && !wdata[B_FIN] && !done) |=> !fin_flag);
    // R10
    fin_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_STAT && wdata[B_FIN] && fin_flag) |=> fin_flag);
    // R11
    gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fin_flag) |-> (hi_cnt >= 16'(CLK_DIV)));
endmodule

bind spi_flash_cmd_ctrl sfc_chk #(.CLK_DIV(CLK_DIV)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .fin_flag(fin_flag), .busy(busy), .done(done), .ctrlb_val(ctrlb_val)
);

// File: tb/tb_spi_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_spi_flash_cmd_ctrl;
    localparam int CLK_DIV = 4;
    localparam logic [4:0] A_CA = 5'h00, A_CB = 5'h04, A_ST = 5'h08, A_TX = 5'h0C, A_RX = 5'h10;

    // ctrlB, tx, reply, exp_rx, exp_seen, exp_nbytes(4), exp_cs(4)
    localparam logic [167:0] VEC [0:4] = '{
        {32'h0000_00B1, 32'h0000_009F, 32'hC220_1700, 32'h00C2_2017, 32'h9F00_0000, 4'd4, 4'b1110},
        {32'h0000_1084, 32'h5634_12D8, 32'h0000_0000, 32'h00C2_2017, 32'hD812_3456, 4'd4, 4'b1101},
        {32'h0000_20A2, 32'h0000_BBAA, 32'h1122_3344, 32'h0000_2233, 32'hAABB_0000, 4'd4, 4'b1011},
        {32'h0000_3087, 32'h4433_2211, 32'h0000_0000, 32'h0000_2233, 32'h1122_3344, 4'd4, 4'b0111},
        {32'h0000_00C1, 32'h0000_009F, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'h9F00_0000, 4'd5, 4'b1110}
    };

    logic        clk = 0, rst_n = 0, wr_en = 0, spi_miso = 0;
    logic [4:0]  addr = 0;
    logic [31:0] wdata = 0, rdata;
    logic        spi_sck, spi_mosi;
    logic [3:0]  spi_cs_n;

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    spi_flash_cmd_ctrl #(.CLK_DIV(CLK_DIV)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #2.5 clk = ~clk;

    // flash responder
    logic [31:0] reply_word = 0;
    logic [7:0]  flash_st = 0, shreg = 0, opcode = 0;
    logic [7:0]  seen [0:7];
    logic [3:0]  cs_seen = 4'hF;
    int          nbits = 0, nseen = 0, cs_falls = 0;
    logic        cs_prev = 0, sck_prev = 1;
    wire         cs_any = ~&spi_cs_n;

    always @(spi_sck or cs_any) begin
        if (cs_any && !cs_prev) begin
            nbits = 0; nseen = 0; cs_seen = spi_cs_n; cs_falls++;
            for (int i = 0; i < 8; i++) seen[i] = 8'h00;
        end
        if (cs_any && spi_sck && !sck_prev) begin
            shreg = {shreg[6:0], spi_mosi};
            nbits++;
            if (nbits % 8 == 0) begin
                if (nseen < 8) seen[nseen] = shreg;
                nseen++;
                if (nbits == 8) opcode = shreg;
            end
        end
        if (cs_any && !spi_sck && sck_prev && nbits >= 8) begin
            if (nbits - 8 < 32)
                spi_miso = (opcode == 8'h05) ? (({flash_st, 24'h0} >> (39 - nbits)) & 1) != 0
                                             : ((reply_word >> (39 - nbits)) & 1) != 0;
            else
                spi_miso = 1'b0;
        end
        if (!cs_any && cs_prev && opcode == 8'h06 && nbits == 8) flash_st[1] = 1'b1;
        cs_prev  = cs_any;
        sck_prev = spi_sck;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); wr_en = 0; addr = a; #1; d = rdata;
    endtask

    // R11: waits for the finish flag, checking the chip-select high run before it
    task automatic wait_fin();
        int  hi = 0;
        bit  ok = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk); addr = A_ST; #1;
            if (rdata[8]) begin ok = 1; break; end
            if (&spi_cs_n) hi++; else hi = 0;
        end
        chk("R10 flag set on completion", {31'h0, ok}, 32'h1);
        chk("R11 cs high run before flag", (hi >= CLK_DIV) ? 32'h1 : 32'h0, 32'h1);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int f0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(A_CA, d); chk("R1 ctrlA reset", d, 0);
        rd(A_CB, d); chk("R1 ctrlB reset", d, 0);
        rd(A_ST, d); chk("R1 status reset", d, 0);
        rd(A_TX, d); chk("R1 tx reset", d, 0);
        rd(A_RX, d); chk("R1 rx reset", d, 0);
        chk("R1 cs idle", {28'h0, spi_cs_n}, 32'hF);
        chk("R1 sck idle", {31'h0, spi_sck}, 32'h1);
        // R3 ctrlA holds only bits 29:28
        wr(A_CA, 32'hFFFF_FFFF); rd(A_CA, d); chk("R3 ctrlA mask", d, 32'h3000_0000);

        // table-driven generic transfers: R4 R5 R6 R9
        for (int v = 0; v < 5; v++) begin
            reply_word = VEC[v][103:72];
            wr(A_TX, VEC[v][135:104]);
            wr(A_ST, 32'h0);
            f0 = cs_falls;
            wr(A_CB, VEC[v][167:136]);
            wait_fin();
            rd(A_RX, d); chk("R6 rx packing", d, VEC[v][71:40]);
            chk("R5 byte order", {seen[0], seen[1], seen[2], seen[3]}, VEC[v][39:8]);
            chk("R4 byte count", 32'(nseen), 32'(VEC[v][7:4]));
            chk("R9 bank select", {28'h0, cs_seen}, {28'h0, VEC[v][3:0]});
            chk("R11 single cs low period", 32'(cs_falls - f0), 32'h1);
        end

        // R7 status read before write enable
        wr(A_ST, 32'h0);
        wr(A_CB, 32'h0000_0400);
        wait_fin();
        rd(A_ST, d); chk("R7 status byte", d, 32'h0000_0100);
        // R10 writing one keeps flag, zero clears it
        wr(A_ST, 32'h0000_01FF); rd(A_ST, d); chk("R10 keep flag", d, 32'h0000_0100);
        wr(A_ST, 32'h0000_0000); rd(A_ST, d); chk("R10 clear flag", d, 32'h0);

        // R8 write enable with priority over status read and send
        wr(A_CB, 32'h0000_0C80);
        wait_fin();
        chk("R8 one byte", 32'(nseen), 32'h1);
        chk("R8 opcode", {24'h0, seen[0]}, 32'h06);
        wr(A_ST, 32'h0);
        wr(A_CB, 32'h0000_0400);
        wait_fin();
        rd(A_ST, d); chk("R7 status after write enable", d, 32'h0000_0102);

        // R12 control B write while busy
        wr(A_ST, 32'h0);
        wr(A_TX, 32'h0000_009F);
        reply_word = 32'hA1B2_C3D4;
        f0 = cs_falls;
        wr(A_CB, 32'h0000_10C1);
        wr(A_CB, 32'h0000_2481);
        wait_fin();
        repeat (4 * CLK_DIV) @(negedge clk);
        rd(A_CB, d); chk("R12 ctrlB unchanged", d, 32'h0000_10C1);
        chk("R12 no second transfer", 32'(cs_falls - f0), 32'h1);
        chk("R12 bank kept", {28'h0, cs_seen}, 32'hD);
        rd(A_RX, d); chk("R6 four-byte receive", d, 32'hA1B2_C3D4);
        // R2 bus idles with clock high
        chk("R2 sck idle high", {31'h0, spi_sck}, 32'h1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule